// File: doc/BRIEF.md
# Link Pulse Burst Decoder

This block turns a train of single-cycle pulse strobes into a 16-bit link code word. A burst is framed by clock pulses that are always present. Each clock pulse opens a data window, and one data bit is decided inside that window: a pulse in the window means 1, no pulse means 0. Pulses are told apart only by the number of cycles since the last accepted clock pulse. A pulse that arrives early in the gap is ignored. A pulse in the middle of the gap is data. A pulse late in the gap is the next clock pulse.

The burst ends when no pulse arrives for `CLK_MAX` cycles. If the burst had exactly 17 clock pulses, and so 16 data decisions, the decoder publishes the word with a one-cycle valid strobe. Any other count raises a one-cycle error strobe and the word is dropped. After the end of a burst the framing logic is idle, and the next pulse starts a new burst. The block does not detect analog pulses and does not act on the contents of the word.

Top module: `flp_decoder`

## Requirements
- R1: After reset, or once a burst has ended, the next pulse is taken as clock pulse 1. Inside a burst, a pulse that arrives more than `DATA_MAX` and at most `CLK_MAX` cycles after the last clock pulse is the next clock pulse.
- R2: A pulse that arrives `DATA_MIN` to `DATA_MAX` cycles (inclusive) after a clock pulse sets that slot's bit to 1. A slot with no such pulse gives 0. Pulses arriving fewer than `DATA_MIN` cycles after a clock pulse are ignored.
- R3: The first data bit of a burst lands in `word_o[0]`, and each later bit goes one position higher, up to bit 15.
- R4: The selector field, made of the first five bits received, appears in `word_o[4:0]`.
- R5: The burst ends when `CLK_MAX` cycles pass with no pulse. If exactly 17 clock pulses were counted, `word_vld_o` is high for one cycle, the cycle after the last pulse-free cycle. `word_o` takes the new word in that same cycle and holds it until the next valid word.
- R6: A burst that ends with fewer than 17 clock pulses (a single stray pulse included) raises `err_o` for one cycle, does not assert `word_vld_o`, and leaves `word_o` unchanged.
- R7: A burst with more than 17 clock pulses raises `err_o` for one cycle and leaves `word_o` unchanged.
- R8: `word_vld_o` and `err_o` are never high together. Each is high for a single cycle per burst. A new burst that follows an idle gap decodes independently of the previous one.
- R9: While `rst_n` is low, `word_o`, `word_vld_o` and `err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_i | input | 1 | Single-cycle strobe, one per detected link pulse |
| word_o | output | 16 | Last well-formed link code word, first bit in bit 0 |
| word_vld_o | output | 1 | One-cycle strobe when a new word is published |
| err_o | output | 1 | One-cycle strobe when a malformed burst is dropped |

## Verification
The assertions check on every cycle that the two strobes are exclusive and last one cycle each. They also check that the word only changes together with the valid strobe, and that a strobe only follows a pulse-free cycle. Only the bench scenarios can show that the decoded value is right. This covers the bit order and selector position, the inclusive edges of the data window, the ignored early pulses, and the exact count of 17 clock pulses that separates a published word from a short or overlong burst that is rejected.

// File: rtl/flp_decoder.sv
module flp_decoder #(
  parameter int DATA_MIN = 4,
  parameter int DATA_MAX = 10,
  parameter int CLK_MAX  = 20,
  parameter int WORD_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pulse_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              err_o
);

  localparam int NCLK  = WORD_W + 1;
  localparam int GAP_W = $clog2(CLK_MAX + 1);
  localparam int CNT_W = $clog2(NCLK + 2);

  localparam logic [GAP_W-1:0] G_DMIN = GAP_W'(DATA_MIN);
  localparam logic [GAP_W-1:0] G_DMAX = GAP_W'(DATA_MAX);
  localparam logic [GAP_W-1:0] G_CMAX = GAP_W'(CLK_MAX);
  localparam logic [CNT_W-1:0] C_FULL = CNT_W'(NCLK);

  logic              active;
  logic [GAP_W-1:0]  gap;
  logic [CNT_W-1:0]  nclk;
  logic              dbit;
  logic [WORD_W-1:0] shreg;

  wire in_data  = (gap >= G_DMIN) && (gap <= G_DMAX);
  wire in_clk   = (gap > G_DMAX);
  wire clk_hit  = active && pulse_i && in_clk;
  wire data_hit = active && pulse_i && in_data;
  wire timeout  = active && !pulse_i && (gap == G_CMAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      gap        <= '0;
      nclk       <= '0;
      dbit       <= 1'b0;
      shreg      <= '0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      word_vld_o <= 1'b0;
      err_o      <= 1'b0;
      if (!active) begin
        if (pulse_i) begin
          active <= 1'b1;
          gap    <= GAP_W'(1);
          nclk   <= CNT_W'(1);
          dbit   <= 1'b0;
        end
      end else if (timeout) begin
        active <= 1'b0;
        if (nclk == C_FULL) begin
          word_o     <= shreg;
          word_vld_o <= 1'b1;
        end else begin
          err_o <= 1'b1;
        end
      end else if (clk_hit) begin
        gap  <= GAP_W'(1);
        dbit <= 1'b0;
        if (nclk <= C_FULL) nclk <= nclk + 1'b1;
        if (nclk < C_FULL) shreg <= {dbit, shreg[WORD_W-1:1]};
      end else begin
        gap <= gap + 1'b1;
        if (data_hit) dbit <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/flp_decoder_chk.sv
module flp_decoder_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pulse_i,
  input logic [WORD_W-1:0] word_o,
  input logic              word_vld_o,
  input logic              err_o
);

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_vld_o && err_o));

  // R5
  vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |=> !word_vld_o);

  // R6
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  // R5
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld_o |-> $stable(word_o));

  // R5
  vld_after_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |-> !$past(pulse_i));

  // R6
  err_after_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !$past(pulse_i));

endmodule

bind flp_decoder flp_decoder_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pulse_i(pulse_i),
  .word_o(word_o), .word_vld_o(word_vld_o), .err_o(err_o)
);

// File: tb/flp_decoder_tb.sv
module flp_decoder_tb;

  localparam int DMIN = 4;
  localparam int DMAX = 10;
  localparam int CMAX = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pulse_i = 1'b0;
  logic [15:0] word_o;
  logic        word_vld_o, err_o;

  int checks = 0;
  int errors = 0;
  int vld_cnt = 0;
  int err_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flp_decoder #(.DATA_MIN(DMIN), .DATA_MAX(DMAX), .CLK_MAX(CMAX), .WORD_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .pulse_i(pulse_i),
    .word_o(word_o), .word_vld_o(word_vld_o), .err_o(err_o)
  );

  always @(negedge clk) begin
    if (rst_n && word_vld_o) vld_cnt++;
    if (rst_n && err_o) err_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic emit(input logic p);
    pulse_i = p;
    @(negedge clk);
  endtask

  task automatic send_burst(input logic [15:0] w, input int nclk, input int doff, input int per);
    for (int k = 0; k < nclk; k++) begin
      emit(1'b1);
      if (k < nclk - 1)
        for (int j = 1; j < per; j++) emit((j == doff) && (k < 16) && w[k]);
    end
    repeat (CMAX + 4) emit(1'b0);
  endtask

  task automatic expect_word(input logic [15:0] w, input int nclk, input int doff, input int per,
                             input logic [15:0] exp, input string req);
    int v0 = vld_cnt;
    int e0 = err_cnt;
    send_burst(w, nclk, doff, per);
    chk(vld_cnt - v0 == 1, req, vld_cnt - v0, 1);
    chk(err_cnt == e0, req, err_cnt - e0, 0);
    chk(word_o == exp, req, word_o, exp);
  endtask

  task automatic expect_err(input int nclk, input string req);
    logic [15:0] prev = word_o;
    int v0 = vld_cnt;
    int e0 = err_cnt;
    send_burst(16'hFFFF, nclk, 6, 14);
    chk(err_cnt - e0 == 1, req, err_cnt - e0, 1);
    chk(vld_cnt == v0, req, vld_cnt - v0, 0);
    chk(word_o == prev, req, word_o, prev);
  endtask

  task automatic t_reset;
    chk(word_o == 16'h0, "R9 word", word_o, 0);
    chk(word_vld_o == 1'b0, "R9 vld", word_vld_o, 0);
    chk(err_o == 1'b0, "R9 err", err_o, 0);
  endtask

  task automatic t_basic;
    expect_word(16'hA5C3, 17, 7, 16, 16'hA5C3, "R1 R3 basic");
    expect_word(16'h0000, 17, 7, 16, 16'h0000, "R2 zeros");
    expect_word(16'hFFFF, 17, 7, 16, 16'hFFFF, "R2 ones");
  endtask

  task automatic t_order;
    expect_word(16'h0001, 17, 6, 12, 16'h0001, "R3 first bit low");
    chk(word_o[4:0] == 5'h01, "R4 selector", word_o[4:0], 1);
    expect_word(16'h8000, 17, 6, 12, 16'h8000, "R3 last bit high");
    expect_word(16'h0013, 17, 6, 12, 16'h0013, "R4 selector word");
    chk(word_o[4:0] == 5'h13, "R4 selector", word_o[4:0], 5'h13);
  endtask

  task automatic t_window;
    expect_word(16'h3C5A, 17, DMIN, DMAX + 1, 16'h3C5A, "R2 window low edge");
    expect_word(16'h5A3C, 17, DMAX, CMAX, 16'h5A3C, "R2 R1 window high edge");
    expect_word(16'hFFFF, 17, DMIN - 1, 14, 16'h0000, "R2 early pulse ignored");
  endtask

  task automatic t_errors;
    expect_err(16, "R6 short by one");
    expect_err(1, "R6 stray pulse");
    expect_err(18, "R7 overlong");
  endtask

  task automatic t_back2back;
    expect_word(16'h1234, 17, 5, 13, 16'h1234, "R8 first");
    expect_word(16'hFEDC, 17, 9, 18, 16'hFEDC, "R8 second");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_order();
    t_window();
    t_errors();
    t_back2back();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule